// File: doc/BRIEF.md
# Multiplexed Character Scan Sequencer

This block drives an eight-position character display one position at a time. A one-cycle oscillator tick, sampled on the system clock, advances a divide-by-64 prescaler. Each time the prescaler wraps, a slot counter moves to the next character position. After the eighth position it returns to the first. The slot number is presented as the read address of the display memory. The 6-bit code that comes back is forwarded to an external font lookup. The 17-bit segment pattern that the lookup returns (sixteen segments and a decimal point) is placed on the segment outputs. A one-hot select vector marks which character is lit.

Adjacent characters are separated by a blanking window: every output is held inactive while the prescaler count is zero. A write in progress also forces all outputs inactive but leaves the scan running. An off input blanks the display and holds both counters at zero. The memory contents are not touched.

Top module: `char_scan_seq`

## Requirements
- R1: After reset, `char_sel` and `seg_out` are all zero and `mem_addr` is 0.
- R2: The prescaler advances only on a clock cycle with `tick` high. The slot number shown on `mem_addr` increases by one after every 64 ticks and returns to 0 after slot 7, so a full frame takes 512 ticks.
- R3: `mem_addr` always equals the current slot number, and `font_code` equals `mem_code` in the same cycle.
- R4: While the prescaler count is 0 (the first of each 64 ticks of a slot), `char_sel` and `seg_out` are all zero one clock later.
- R5: Outside blanking, write and off, `seg_out` equals the `font_seg` value of the current slot's code, and `char_sel` has only bit `slot` set. Both are registered and change in the same clock, one cycle after the slot state.
- R6: `char_sel` never has more than one bit set. Bit 0 is the leftmost character and is driven by slot 0.
- R7: `wr_busy` high forces `char_sel` and `seg_out` to zero on the next clock. The scan position is unaffected and the display resumes at the same slot once `wr_busy` falls.
- R8: `off` high forces `char_sel` and `seg_out` to zero on the next clock and clears the prescaler and slot to 0. Ticks are ignored while `off` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle oscillator pulse |
| off | input | 1 | Display shutdown; clears counters |
| wr_busy | input | 1 | Qualifying write in progress; blanks outputs |
| mem_addr | output | 3 | Display memory read address (current slot) |
| mem_code | input | 6 | Character code read from memory |
| font_code | output | 6 | Code sent to the font lookup |
| font_seg | input | 17 | Segment pattern returned by the font lookup |
| seg_out | output | 17 | Gated segment drive, active high |
| char_sel | output | 8 | One-hot character select, active high |

## Verification
The hardest state to reach from the ports is the frame wrap. Slot 7 hands back to slot 0 only after 512 ticks, and the blanking cycle must fall exactly at that boundary. The bench counts every tick it issues and derives the expected prescaler and slot values from that count alone. It then walks the scan through all eight slots and past the wrap, sampling just after each boundary and in the middle of each slot. Writes and shutdown are applied mid-slot so that both kinds of recovery can be seen: resuming at the same slot after a write, and restarting from zero after shutdown.

// File: rtl/char_scan_seq.sv
module char_scan_seq #(
  parameter int NUM_SLOTS = 8,
  parameter int PRESCALE  = 64,
  parameter int CODE_W    = 6,
  parameter int SEG_W     = 17
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         off,
  input  logic                         wr_busy,
  output logic [$clog2(NUM_SLOTS)-1:0] mem_addr,
  input  logic [CODE_W-1:0]            mem_code,
  output logic [CODE_W-1:0]            font_code,
  input  logic [SEG_W-1:0]             font_seg,
  output logic [SEG_W-1:0]             seg_out,
  output logic [NUM_SLOTS-1:0]         char_sel
);
  localparam int PRE_W  = $clog2(PRESCALE);
  localparam int ADDR_W = $clog2(NUM_SLOTS);

  logic [PRE_W-1:0]  pre_q;
  logic [ADDR_W-1:0] slot_q;

  wire pre_last  = (pre_q == PRE_W'(PRESCALE - 1));
  wire slot_last = (slot_q == ADDR_W'(NUM_SLOTS - 1));
  wire quiet     = off | wr_busy | (pre_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || off) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else if (tick) begin
      pre_q <= pre_last ? '0 : pre_q + 1'b1;
      if (pre_last)
        slot_q <= slot_last ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_out  <= '0;
      char_sel <= '0;
    end else begin
      seg_out  <= quiet ? '0 : font_seg;
      char_sel <= quiet ? '0 : (NUM_SLOTS'(1) << slot_q);
    end
  end

  assign mem_addr  = slot_q;
  assign font_code = mem_code;
endmodule

// File: rtl/char_scan_seq_chk.sv
module char_scan_seq_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int CODE_W    = 6,
  parameter int SEG_W     = 17
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick,
  input logic                         off,
  input logic                         wr_busy,
  input logic [$clog2(NUM_SLOTS)-1:0] mem_addr,
  input logic [CODE_W-1:0]            mem_code,
  input logic [CODE_W-1:0]            font_code,
  input logic [SEG_W-1:0]             seg_out,
  input logic [NUM_SLOTS-1:0]         char_sel
);
  localparam int ADDR_W = $clog2(NUM_SLOTS);

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(char_sel));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !off) |=> $stable(mem_addr));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !off |=> (mem_addr == $past(mem_addr) || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    font_code == mem_code);

  p_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_sel != '0) |-> (char_sel == (NUM_SLOTS'(1) << $past(mem_addr))));

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |=> (char_sel == '0 && seg_out == '0));

  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (char_sel == '0 && seg_out == '0 && mem_addr == '0));
endmodule

bind char_scan_seq char_scan_seq_chk #(
  .NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W), .SEG_W(SEG_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .off(off), .wr_busy(wr_busy),
  .mem_addr(mem_addr), .mem_code(mem_code), .font_code(font_code),
  .seg_out(seg_out), .char_sel(char_sel)
);

// File: tb/char_scan_seq_tb.sv
module char_scan_seq_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, off = 0, wr_busy = 0;
  logic [2:0]  mem_addr;
  logic [5:0]  mem_code, font_code;
  logic [16:0] font_seg, seg_out;
  logic [7:0]  char_sel;
  logic [5:0]  mem [8];
  int n_run = 0, n_fail = 0, ticks = 0, cyc = 0;

  always #5 clk = ~clk;

  function automatic logic [16:0] fseg(input logic [5:0] c);
    return {c, c ^ 6'h2A, c[4:0]};
  endfunction

  assign mem_code = mem[mem_addr];
  assign font_seg = fseg(font_code);

  char_scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .off(off), .wr_busy(wr_busy),
    .mem_addr(mem_addr), .mem_code(mem_code), .font_code(font_code),
    .font_seg(font_seg), .seg_out(seg_out), .char_sel(char_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input int n, input bit counted);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      if (counted) ticks++;
    end
    @(negedge clk);
  endtask

  task automatic expect_scan(input string req);
    int pre = ticks % 64;
    int slot = (ticks / 64) % 8;
    chk({req, " addr"}, 32'(mem_addr), 32'(slot));
    chk({req, " code"}, 32'(font_code), 32'(mem[slot]));
    if (pre == 0) begin
      chk({req, " blank sel"}, 32'(char_sel), 0);
      chk({req, " blank seg"}, 32'(seg_out), 0);
    end else begin
      chk({req, " sel"}, 32'(char_sel), 32'(8'd1 << slot));
      chk({req, " seg"}, 32'(seg_out), 32'(fseg(mem[slot])));
    end
  endtask

  task automatic t_reset;
    chk("R1 sel", 32'(char_sel), 0);
    chk("R1 seg", 32'(seg_out), 0);
    chk("R1 addr", 32'(mem_addr), 0);
  endtask

  task automatic t_first_slot;
    pulse(1, 1);
    expect_scan("R5 slot0 first tick");
    chk("R6 leftmost bit0", 32'(char_sel), 1);
    repeat (5) @(negedge clk);
    expect_scan("R2 no tick no move");
  endtask

  task automatic t_boundaries;
    pulse(63 - ticks % 64, 1);
    expect_scan("R2 end of slot0");
    pulse(1, 1);
    expect_scan("R4 blank at boundary");
    pulse(1, 1);
    expect_scan("R5 slot1 after blank");
  endtask

  task automatic t_walk;
    for (int s = 0; s < 8; s++) begin
      pulse(64 - ticks % 64, 1);
      expect_scan("R4 boundary walk");
      pulse(32, 1);
      expect_scan("R3 mid slot walk");
    end
  endtask

  task automatic t_wrap;
    pulse(512 - ticks % 512 - 1, 1);
    expect_scan("R2 slot7 last tick");
    chk("R6 slot7 bit7", 32'(char_sel), 32'h80);
    pulse(1, 1);
    expect_scan("R2 wrap blank");
    pulse(1, 1);
    expect_scan("R2 wrap slot0");
  endtask

  task automatic t_pattern;
    for (int i = 0; i < 8; i++) mem[i] = 6'(63 - i * 9);
    pulse(64 * 3 + 10, 1);
    expect_scan("R5 new pattern");
    @(negedge clk);
    expect_scan("R5 new pattern hold");
  endtask

  task automatic t_write;
    int slot = (ticks / 64) % 8;
    @(negedge clk) wr_busy = 1;
    @(negedge clk);
    chk("R7 busy sel", 32'(char_sel), 0);
    chk("R7 busy seg", 32'(seg_out), 0);
    pulse(3, 1);
    chk("R7 busy still quiet", 32'(char_sel), 0);
    wr_busy = 0;
    @(negedge clk);
    chk("R7 resumes same slot", 32'(mem_addr), 32'(slot));
    expect_scan("R7 after write");
  endtask

  task automatic t_off;
    @(negedge clk) off = 1;
    @(negedge clk);
    chk("R8 off sel", 32'(char_sel), 0);
    chk("R8 off seg", 32'(seg_out), 0);
    chk("R8 off addr", 32'(mem_addr), 0);
    pulse(100, 0);
    chk("R8 ticks ignored", 32'(mem_addr), 0);
    off = 0;
    ticks = 0;
    @(negedge clk);
    expect_scan("R8 restart blank");
    pulse(1, 1);
    expect_scan("R8 restart slot0");
    pulse(64, 1);
    expect_scan("R8 restart slot1");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 6'(i * 7 + 3);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_first_slot();
    t_boundaries();
    t_walk();
    t_wrap();
    t_pattern();
    t_write();
    t_off();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule